// File: doc/BRIEF.md
# Time-Multiplexed Park Rotation Engine

This block rotates a two-phase current sample (alpha, beta) into the rotating reference frame. It produces the direct component d and the quadrature component q from a sine/cosine pair. The fast clock runs many times faster than the sample rate, so one sample period holds a large number of clock cycles. The block uses this headroom to pass all four rotation products through a single signed multiplier. A free-running period counter marks the position inside each sample period. The counter opens a capture window at position 0, four multiply slots after it, and the accumulation steps that follow.

The result is presented in one of two ways, chosen by a parameter. In low-latency mode d, q and a one-cycle valid pulse appear at a fixed phase of 10 clock cycles into the same period. In registered mode they appear at the start of the next period and then hold for a full period, like a down-sampled value. Either way the result is complete before the next sample is captured, so the shared multiplier costs no sample-period latency. Operands and results are signed 16-bit Q1.15.

Top module: `park_rotor`

## Requirements
- R1: While the active-low synchronous reset is asserted, d_o, q_o and res_vld are 0.
- R2: The period counter is 0 in the first clock cycle after reset release. It steps by one each cycle up to PERIOD-1 (default 800) and then wraps to 0. A cycle with the counter at 0 is a sample boundary.
- R3: Operands are captured only when smp_stb is high in a boundary cycle. A strobe in any other cycle has no effect on outputs.
- R4: The four products are formed by one multiplier in the four cycles after the boundary, in the order alpha*cos, beta*sin, beta*cos, alpha*sin. The product register holds in every other cycle.
- R5: d_o equals (alpha*cos + beta*sin) computed exactly in 33 bits, arithmetically shifted right by 15, then saturated to 16 bits.
- R6: q_o equals (beta*cos - alpha*sin) computed exactly in 33 bits, arithmetically shifted right by 15, then saturated to 16 bits.
- R7: Saturation clamps the result to 32767 above and to -32768 below.
- R8: With LOW_LAT=1, d_o, q_o and a one-cycle res_vld pulse appear at counter value OUT_PHASE (default 10) of the period in which the sample was captured. The outputs are otherwise held.
- R9: With LOW_LAT=0, d_o, q_o and a one-cycle res_vld pulse appear at counter value 0 of the period after capture. The outputs never change at any other counter value.
- R10: If no sample was captured at a boundary, no valid pulse follows for that period and d_o and q_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample strobe, honoured only in a boundary cycle |
| alpha_i | input | 16 | Alpha current, signed Q1.15 |
| beta_i | input | 16 | Beta current, signed Q1.15 |
| cos_i | input | 16 | Cosine of rotor angle, signed Q1.15 |
| sin_i | input | 16 | Sine of rotor angle, signed Q1.15 |
| d_o | output | 16 | Direct component, signed Q1.15 |
| q_o | output | 16 | Quadrature component, signed Q1.15 |
| res_vld | output | 1 | One-cycle pulse marking a new d/q result |

## Verification
The hardest situation to reach is a sample whose two products sum past the 32-bit range, which is where the 33-bit accumulator and the clamp must work together. Reaching it takes full-scale negative operands on both sides of the sum. The stimulus sweeps every combination of a small set of extreme and ordinary Q1.15 values over all four operands, one sample per period, so both clamp directions and the exact-zero cases occur. Two instances, one per output mode, run on the same stimulus. Periods with no strobe, and with a strobe placed off the boundary, show that the held outputs stay put.

// File: rtl/park_pkg.sv
// Shared types for the Park rotation engine.
// Assumes the four products are issued in a fixed slot order after capture.
package park_pkg;
    // Multiplier slot, in issue order after the sample boundary.
    typedef enum logic [1:0] {
        SLOT_AC = 2'd0,   // alpha * cos
        SLOT_BS = 2'd1,   // beta  * sin
        SLOT_BC = 2'd2,   // beta  * cos
        SLOT_AS = 2'd3    // alpha * sin
    } mul_slot_e;
endpackage

// File: rtl/park_sched.sv
// Period scheduler: a counter free-running over 0..PERIOD-1.
// Assumes PERIOD >= 8 so that all compute slots fit inside one period.
module park_sched #(
    parameter int PERIOD = 800,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Step the position inside the sample period, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_o <= '0;
        else if (cnt_o == LAST) cnt_o <= '0;
        else                    cnt_o <= cnt_o + CW'(1);
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == LAST) |=> (cnt_o == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != LAST) |=> (cnt_o == $past(cnt_o) + CW'(1)));
endmodule

// File: rtl/park_mac.sv
// Shared multiply-accumulate: captures operands at the boundary, then runs
// four products through one multiplier and builds the d and q sums.
// Assumes the counter comes from park_sched and counts 0,1,2,...
module park_mac
    import park_pkg::*;
#(
    parameter int DW     = 16,
    parameter int PERIOD = 800,
    localparam int CW    = $clog2(PERIOD),
    localparam int PW    = 2 * DW,
    localparam int AW    = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 stb_i,
    input  logic signed [DW-1:0] alpha_i,
    input  logic signed [DW-1:0] beta_i,
    input  logic signed [DW-1:0] cos_i,
    input  logic signed [DW-1:0] sin_i,
    output logic                 armed_o,
    output logic signed [AW-1:0] acc_d_o,
    output logic signed [AW-1:0] acc_q_o
);
    logic signed [DW-1:0] ra, rb, rc, rs;
    logic signed [DW-1:0] ma, mb;
    logic signed [PW-1:0] prod, prod_q;
    logic signed [AW-1:0] prod_x;
    logic                 mul_en;
    mul_slot_e            slot;

    // Latch the sample and the period's armed flag at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
            ra <= '0; rb <= '0; rc <= '0; rs <= '0;
        end else if (cnt_i == '0) begin
            armed_o <= stb_i;
            if (stb_i) begin
                ra <= alpha_i; rb <= beta_i; rc <= cos_i; rs <= sin_i;
            end
        end
    end

    // Counter values 1..4 are the multiplier slots.
    always_comb begin
        mul_en = armed_o && (cnt_i >= CW'(1)) && (cnt_i <= CW'(4));
        slot   = mul_slot_e'(cnt_i[1:0] - 2'd1);
    end

    // Route the slot's operand pair into the shared multiplier.
    always_comb begin
        case (slot)
            SLOT_AC: begin ma = ra; mb = rc; end
            SLOT_BS: begin ma = rb; mb = rs; end
            SLOT_BC: begin ma = rb; mb = rc; end
            default: begin ma = ra; mb = rs; end
        endcase
        prod   = ma * mb;
        prod_x = AW'(prod_q);
    end

    // The single product register, enabled only in its slots.
    always_ff @(posedge clk) begin
        if (!rst_n)      prod_q <= '0;
        else if (mul_en) prod_q <= prod;
    end

    // Fold each product into its accumulator one cycle after it is formed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_d_o <= '0;
            acc_q_o <= '0;
        end else if (armed_o) begin
            if (cnt_i == CW'(2)) acc_d_o <= prod_x;
            if (cnt_i == CW'(3)) acc_d_o <= acc_d_o + prod_x;
            if (cnt_i == CW'(4)) acc_q_o <= prod_x;
            if (cnt_i == CW'(5)) acc_q_o <= acc_q_o - prod_x;
        end
    end

    a_r4_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_en |=> $stable(prod_q));
    a_r3_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |=> ($stable(ra) && $stable(rb) && $stable(rc) && $stable(rs)));
    a_r5_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_d_o <= (AW'(1) <<< (PW - 1))) && (acc_d_o >= -(AW'(1) <<< (PW - 1))));
endmodule

// File: rtl/park_out.sv
// Output stage: saturates the sums to DW bits and presents them either at a
// fixed phase in the capture period or at the next boundary.
// Assumes OUT_PHASE lies after the last accumulate step (counter 5).
module park_out #(
    parameter int DW        = 16,
    parameter int PERIOD    = 800,
    parameter int OUT_PHASE = 10,
    parameter bit LOW_LAT   = 1'b1,
    localparam int CW       = $clog2(PERIOD),
    localparam int AW       = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 armed_i,
    input  logic signed [AW-1:0] acc_d_i,
    input  logic signed [AW-1:0] acc_q_i,
    output logic signed [DW-1:0] d_o,
    output logic signed [DW-1:0] q_o,
    output logic                 vld_o
);
    localparam int FRAC    = DW - 1;
    localparam int LOAD_AT = LOW_LAT ? OUT_PHASE - 1 : PERIOD - 1;
    localparam int VIS_AT  = LOW_LAT ? OUT_PHASE : 0;
    localparam logic signed [AW-1:0] SAT_HI = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO = -AW'(2 ** (DW - 1));

    logic load;

    // Rescale a Q2.30-style sum to Q1.15 and clamp it.
    function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] sh;
        sh = v >>> FRAC;
        if (sh > SAT_HI)      return SAT_HI[DW-1:0];
        else if (sh < SAT_LO) return SAT_LO[DW-1:0];
        else                  return sh[DW-1:0];
    endfunction

    // Load point of the selected output mode.
    always_comb load = armed_i && (cnt_i == CW'(LOAD_AT));

    // Present the result and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_o   <= '0;
            q_o   <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= load;
            if (load) begin
                d_o <= clamp(acc_d_i);
                q_o <= clamp(acc_q_i);
            end
        end
    end

    a_r8_vld_phase: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (cnt_i == CW'(VIS_AT)));
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != CW'(VIS_AT)) |-> ($stable(d_o) && $stable(q_o)));
    a_r10_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_i && cnt_i == CW'(LOAD_AT)) |=> !vld_o);
endmodule

// File: rtl/park_rotor.sv
// Park rotation engine: d = a*cos + b*sin, q = b*cos - a*sin, computed
// with one shared multiplier inside each sample period.
// Assumes samples arrive with smp_stb in the boundary cycle of the counter.
module park_rotor #(
    parameter int DW        = 16,
    parameter int PERIOD    = 800,
    parameter int OUT_PHASE = 10,
    parameter bit LOW_LAT   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] alpha_i,
    input  logic signed [DW-1:0] beta_i,
    input  logic signed [DW-1:0] cos_i,
    input  logic signed [DW-1:0] sin_i,
    output logic signed [DW-1:0] d_o,
    output logic signed [DW-1:0] q_o,
    output logic                 res_vld
);
    localparam int CW = $clog2(PERIOD);
    localparam int AW = 2 * DW + 1;

    logic [CW-1:0]        cnt;
    logic                 armed;
    logic signed [AW-1:0] acc_d, acc_q;

    park_sched #(.PERIOD(PERIOD)) u_sched (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt)
    );

    park_mac #(.DW(DW), .PERIOD(PERIOD)) u_mac (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .stb_i(smp_stb),
        .alpha_i(alpha_i), .beta_i(beta_i), .cos_i(cos_i), .sin_i(sin_i),
        .armed_o(armed), .acc_d_o(acc_d), .acc_q_o(acc_q)
    );

    park_out #(.DW(DW), .PERIOD(PERIOD), .OUT_PHASE(OUT_PHASE), .LOW_LAT(LOW_LAT)) u_out (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .armed_i(armed),
        .acc_d_i(acc_d), .acc_q_i(acc_q),
        .d_o(d_o), .q_o(q_o), .vld_o(res_vld)
    );
endmodule

// File: tb/park_rotor_tb.sv
// Self-checking bench: both output modes, a sweep over corner operands,
// and periods with no strobe or a strobe off the boundary.
module park_rotor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 40;
    localparam int PH         = 10;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic signed [15:0] alpha_i = '0, beta_i = '0, cos_i = '0, sin_i = '0;
    logic signed [15:0] d_ll, q_ll, d_rg, q_rg;
    logic vld_ll, vld_rg;

    int checks = 0;
    int failures = 0;

    // Expected state of both instances.
    logic signed [15:0] ll_d = '0, ll_q = '0, rg_d = '0, rg_q = '0;
    logic signed [15:0] rp_d = '0, rp_q = '0;
    bit rp_cap = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    park_rotor #(.PERIOD(P), .OUT_PHASE(PH), .LOW_LAT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .alpha_i(alpha_i), .beta_i(beta_i), .cos_i(cos_i), .sin_i(sin_i),
        .d_o(d_ll), .q_o(q_ll), .res_vld(vld_ll)
    );

    park_rotor #(.PERIOD(P), .OUT_PHASE(PH), .LOW_LAT(1'b0)) u_dut_reg (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .alpha_i(alpha_i), .beta_i(beta_i), .cos_i(cos_i), .sin_i(sin_i),
        .d_o(d_rg), .q_o(q_rg), .res_vld(vld_rg)
    );

    function automatic logic signed [15:0] sat16(input longint v);
        longint sh;
        sh = v >>> 15;
        if (sh > 32767)  return 16'sd32767;
        if (sh < -32768) return -16'sd32768;
        return 16'(sh);
    endfunction

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One sample period; stb_k is the cycle carrying the strobe (-1: none).
    task automatic run_period(input int a, input int b, input int c, input int s, input int stb_k);
        bit cap;
        logic signed [15:0] rd, rq;
        cap = (stb_k == 0);
        rd = sat16(longint'(a) * c + longint'(b) * s);   // R5, R7
        rq = sat16(longint'(b) * c - longint'(a) * s);   // R6, R7
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            // Low-latency instance (R2 timing, R8 phase, R10 hold)
            if (k == PH && cap) begin
                ll_d = rd; ll_q = rq;
                chk("R2,R4,R5,R6,R7,R8 result", {vld_ll, d_ll, q_ll}, {1'b1, ll_d, ll_q});
            end else begin
                chk(cap ? "R8 hold" : "R3,R10 no capture", {vld_ll, d_ll, q_ll}, {1'b0, ll_d, ll_q});
            end
            // Registered instance (R9 next-boundary update, R10 hold)
            if (k == 0 && rp_cap) begin
                rg_d = rp_d; rg_q = rp_q;
                chk("R2,R4,R5,R6,R7,R9 result", {vld_rg, d_rg, q_rg}, {1'b1, rg_d, rg_q});
            end else begin
                chk(rp_cap ? "R9 hold" : "R9,R10 hold", {vld_rg, d_rg, q_rg}, {1'b0, rg_d, rg_q});
            end
            smp_stb = (k == stb_k);
            alpha_i = 16'(a); beta_i = 16'(b); cos_i = 16'(c); sin_i = 16'(s);
        end
        rp_cap = cap;
        if (cap) begin rp_d = rd; rp_q = rq; end
    endtask

    initial begin
        int vals [6] = '{-32768, -32767, -1, 0, 1, 23170};
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ll", {vld_ll, d_ll, q_ll}, 33'd0);
        chk("R1 reset reg", {vld_rg, d_rg, q_rg}, 33'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        // Simple first sample, then exhaustive corner sweep.
        run_period(16384, -8192, 23170, 23170, 0);
        foreach (vals[i0]) foreach (vals[i1]) foreach (vals[i2]) foreach (vals[i3])
            run_period(vals[i0], vals[i1], vals[i2], vals[i3], 0);
        // R3: strobe off the boundary is ignored; R10: no strobe at all.
        run_period(1234, -4321, 3000, -3000, 3);
        run_period(-20000, 20000, 32767, 32767, -1);
        run_period(32767, 32767, -32768, 32767, 0);
        run_period(0, 0, 0, 0, P - 1);
        run_period(100, 200, 300, 400, 0);
        run_period(0, 0, 0, 0, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule